// File: doc/BRIEF.md
# Program Sequencer with Return-Address Stack

This block is the control-flow core of a small 8-bit style microcontroller. Each clock cycle a decoder hands it one flow operation, a condition selector, a target address and the current carry and zero flags. The block keeps the program counter, an on-chip stack of return addresses, the interrupt-enable bit and a saved copy of the flags. It then decides where execution goes next. Fetch memory and the arithmetic unit sit outside it. The block drives `pc_o` to the fetch stage. It drives the flag-restore signals back to the flag registers.

An ordinary subroutine return resumes one past the stacked address, because a call stacks its own address. A return from interrupt resumes exactly at the stacked address, because an accepted interrupt stacks the instruction it pre-empted. The interrupt return also hands back the saved carry and zero and sets or clears the interrupt enable, depending on its variant. An interrupt request is taken only while the enable bit is 1. It overrides whatever operation is presented in that cycle.

Top module: `flow_sequencer`

## Requirements
- R1: While reset is low, and after it is released, `pc_o` is 0, `int_en_o` is 0, `stack_err_o` is 0 and the stack is empty.
- R2: With flow operation code 1 (jump), the PC loads `target_i` when the selected condition holds. Otherwise it advances by one. The condition codes are: 0 always, 1 carry set, 2 carry clear, 3 zero set, 4 zero clear, and 5 to 7 never.
- R3: Operation code 2 (call), when its condition holds, pushes the current PC onto the stack and loads `target_i`. When the condition fails, the PC advances by one.
- R4: Operation code 3 (return), when its condition holds and the stack is not empty, pops the stack and loads the popped address plus one. When the condition fails, the PC advances by one.
- R5: Operation codes 4 and 5 (interrupt return) ignore the condition. They pop the stack and load the popped address unchanged. In that same cycle, `flag_restore_o` is 1 and `carry_restore_o` and `zero_restore_o` carry the saved flags.
- R6: Code 4 leaves `int_en_o` at 1 after the interrupt return. Code 5 leaves it at 0.
- R7: Code 6 sets and code 7 clears `int_en_o`. Both advance the PC by one and leave the stack and the saved flags unchanged.
- R8: When `irq_i` is 1 and `int_en_o` is 1, the presented operation is discarded. The current PC is pushed, `carry_i` and `zero_i` are saved, `int_en_o` clears and the PC loads 0x3FF. When `int_en_o` is 0, `irq_i` has no effect.
- R9: A push onto a stack that already holds 31 entries is dropped, and `stack_err_o` sets. The PC still loads its target, and `stack_err_o` stays 1 until reset.
- R10: A taken return or an interrupt return on an empty stack sets `stack_err_o`, advances the PC by one, and changes neither `int_en_o` nor the flag-restore outputs.
- R11: Code 0 advances the PC by one. The PC wraps from 0x3FF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flow_op_i | input | 3 | Decoded flow operation code |
| cond_sel_i | input | 3 | Condition selector |
| target_i | input | 10 | Jump or call target address |
| carry_i | input | 1 | Current carry flag |
| zero_i | input | 1 | Current zero flag |
| irq_i | input | 1 | Interrupt request |
| pc_o | output | 10 | Program counter |
| int_en_o | output | 1 | Interrupt-enable bit |
| flag_restore_o | output | 1 | Load saved flags this cycle |
| carry_restore_o | output | 1 | Saved carry value |
| zero_restore_o | output | 1 | Saved zero value |
| stack_err_o | output | 1 | Sticky stack overflow/underflow |

## Verification
A corrupted stack entry or pointer stays hidden until a later return. At that point `pc_o` lands one cycle after the pop at the wrong address, or off by one if the two return kinds are mixed up. A miscounted pointer shows up as `stack_err_o` rising one call too early or one return too late. A wrong saved-flag or enable value is visible only in the interrupt-return cycle, on the restore outputs, and in `int_en_o` one cycle later. For this reason the stimulus nests calls and interrupts deeply and then unwinds them.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    FLOW_NONE    = 3'd0,
    FLOW_JUMP    = 3'd1,
    FLOW_CALL    = 3'd2,
    FLOW_RET     = 3'd3,
    FLOW_RETI_EN = 3'd4,
    FLOW_RETI_DS = 3'd5,
    FLOW_IE_SET  = 3'd6,
    FLOW_IE_CLR  = 3'd7
  } flow_op_e;

  typedef enum logic [2:0] {
    CND_ALWAYS = 3'd0,
    CND_CY     = 3'd1,
    CND_NCY    = 3'd2,
    CND_ZR     = 3'd3,
    CND_NZR    = 3'd4
  } cond_sel_e;

  // Condition test; unused selector codes never pass.
  function automatic logic cond_met(input logic [2:0] sel, input logic cy, input logic zr);
    case (sel)
      3'd0:    return 1'b1;
      3'd1:    return cy;
      3'd2:    return ~cy;
      3'd3:    return zr;
      3'd4:    return ~zr;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic is_reti(input logic [2:0] op);
    return (op == FLOW_RETI_EN) || (op == FLOW_RETI_DS);
  endfunction

endpackage

// File: rtl/seq_cond_eval.sv
module seq_cond_eval
  import seq_pkg::*;
(
  input  logic [2:0] sel_i,
  input  logic       carry_i,
  input  logic       zero_i,
  output logic       met_o
);
  always_comb met_o = cond_met(sel_i, carry_i, zero_i);
endmodule

// File: rtl/seq_ret_stack.sv
module seq_ret_stack #(
  parameter int AW    = 10,
  parameter int DEPTH = 31
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_i,
  input  logic                         pop_i,
  input  logic [AW-1:0]                wdata_i,
  output logic [AW-1:0]                top_o,
  output logic [$clog2(DEPTH+1)-1:0]   level_o,
  output logic                         full_o,
  output logic                         empty_o
);
  localparam int LW = $clog2(DEPTH+1);
  localparam logic [LW-1:0] LVL_MAX = LW'(DEPTH);

  logic [AW-1:0] mem [DEPTH];
  logic [LW-1:0] level_q;

  assign full_o  = (level_q == LVL_MAX);
  assign empty_o = (level_q == '0);
  assign level_o = level_q;
  assign top_o   = empty_o ? '0 : mem[level_q - 1'b1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= '0;
    end else if (push_i && !full_o) begin
      mem[level_q] <= wdata_i;
      level_q      <= level_q + 1'b1;
    end else if (pop_i && !empty_o) begin
      level_q <= level_q - 1'b1;
    end
  end
endmodule

// File: rtl/flow_sequencer.sv
module flow_sequencer
  import seq_pkg::*;
#(
  parameter int          PC_W   = 10,
  parameter int          DEPTH  = 31,
  parameter logic [9:0]  VECTOR = 10'h3FF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      flow_op_i,
  input  logic [2:0]      cond_sel_i,
  input  logic [PC_W-1:0] target_i,
  input  logic            carry_i,
  input  logic            zero_i,
  input  logic            irq_i,
  output logic [PC_W-1:0] pc_o,
  output logic            int_en_o,
  output logic            flag_restore_o,
  output logic            carry_restore_o,
  output logic            zero_restore_o,
  output logic            stack_err_o
);
  localparam int LW = $clog2(DEPTH+1);
  localparam logic [PC_W-1:0] VEC = PC_W'(VECTOR);

  function automatic logic [PC_W-1:0] pc_step(input logic [PC_W-1:0] pc);
    return pc + 1'b1;
  endfunction

  logic [PC_W-1:0] pc_q, pc_d;
  logic            ie_q, ie_d;
  logic            sv_c_q, sv_z_q;
  logic            err_q;

  // Named internal events, observed by the bound checker.
  logic            cond_ok;
  logic            irq_take, jump_go, call_go, ret_go, reti_go;
  logic            push_req, push_ovf, pop_empty;
  logic [PC_W-1:0] stack_top;
  logic [LW-1:0]   stack_level;
  logic            stk_full, stk_empty;

  seq_cond_eval u_cond (
    .sel_i   (cond_sel_i),
    .carry_i (carry_i),
    .zero_i  (zero_i),
    .met_o   (cond_ok)
  );

  always_comb begin
    irq_take  = irq_i & ie_q;
    jump_go   = !irq_take && flow_op_i == FLOW_JUMP && cond_ok;
    call_go   = !irq_take && flow_op_i == FLOW_CALL && cond_ok;
    ret_go    = !irq_take && flow_op_i == FLOW_RET && cond_ok && !stk_empty;
    reti_go   = !irq_take && is_reti(flow_op_i) && !stk_empty;
    pop_empty = !irq_take && stk_empty &&
                ((flow_op_i == FLOW_RET && cond_ok) || is_reti(flow_op_i));
    push_req  = irq_take || call_go;
    push_ovf  = push_req && stk_full;
  end

  seq_ret_stack #(.AW(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push_req),
    .pop_i   (ret_go || reti_go),
    .wdata_i (pc_q),
    .top_o   (stack_top),
    .level_o (stack_level),
    .full_o  (stk_full),
    .empty_o (stk_empty)
  );

  always_comb begin
    pc_d = pc_step(pc_q);
    if (irq_take)                pc_d = VEC;
    else if (jump_go || call_go) pc_d = target_i;
    else if (ret_go)             pc_d = pc_step(stack_top);
    else if (reti_go)            pc_d = stack_top;
  end

  always_comb begin
    ie_d = ie_q;
    if (irq_take)                        ie_d = 1'b0;
    else if (reti_go)                    ie_d = (flow_op_i == FLOW_RETI_EN);
    else if (flow_op_i == FLOW_IE_SET)   ie_d = 1'b1;
    else if (flow_op_i == FLOW_IE_CLR)   ie_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      ie_q   <= 1'b0;
      sv_c_q <= 1'b0;
      sv_z_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      ie_q  <= ie_d;
      err_q <= err_q | push_ovf | pop_empty;
      if (irq_take) begin
        sv_c_q <= carry_i;
        sv_z_q <= zero_i;
      end
    end
  end

  assign pc_o            = pc_q;
  assign int_en_o        = ie_q;
  assign flag_restore_o  = reti_go;
  assign carry_restore_o = sv_c_q;
  assign zero_restore_o  = sv_z_q;
  assign stack_err_o     = err_q;

endmodule

// File: rtl/flow_sequencer_chk.sv
module flow_sequencer_chk
  import seq_pkg::*;
#(
  parameter int          PC_W   = 10,
  parameter int          DEPTH  = 31,
  parameter logic [9:0]  VECTOR = 10'h3FF
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [2:0]                 flow_op_i,
  input logic [PC_W-1:0]            target_i,
  input logic                       irq_take,
  input logic                       jump_go,
  input logic                       call_go,
  input logic                       ret_go,
  input logic                       reti_go,
  input logic [PC_W-1:0]            stack_top,
  input logic [$clog2(DEPTH+1)-1:0] stack_level,
  input logic [PC_W-1:0]            pc_o,
  input logic                       int_en_o,
  input logic                       stack_err_o
);
  localparam int LW = $clog2(DEPTH+1);

  // R2
  jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jump_go |=> pc_o == $past(target_i));

  // R3
  call_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_go && stack_level != LW'(DEPTH)) |=> stack_level == $past(stack_level) + 1'b1);

  // R4
  ret_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_go |=> pc_o == PC_W'($past(stack_top) + 1'b1));

  // R5
  reti_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reti_go |=> pc_o == $past(stack_top));

  // R6
  reti_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reti_go |=> int_en_o == ($past(flow_op_i) == FLOW_RETI_EN));

  // R8
  irq_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> (pc_o == PC_W'(VECTOR)) && !int_en_o);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stack_err_o |=> stack_err_o);

  // R1
  reset_pc_chk: assert property (@(posedge clk)
    !rst_n |=> pc_o == '0 && !int_en_o && !stack_err_o);
endmodule

bind flow_sequencer flow_sequencer_chk #(.PC_W(PC_W), .DEPTH(DEPTH), .VECTOR(VECTOR)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flow_op_i   (flow_op_i),
  .target_i    (target_i),
  .irq_take    (irq_take),
  .jump_go     (jump_go),
  .call_go     (call_go),
  .ret_go      (ret_go),
  .reti_go     (reti_go),
  .stack_top   (stack_top),
  .stack_level (stack_level),
  .pc_o        (pc_o),
  .int_en_o    (int_en_o),
  .stack_err_o (stack_err_o)
);

// File: tb/flow_sequencer_test.sv
module flow_sequencer_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] flow_op_i, cond_sel_i;
  logic [9:0] target_i;
  logic       carry_i, zero_i, irq_i;
  logic [9:0] pc_o;
  logic       int_en_o, flag_restore_o, carry_restore_o, zero_restore_o, stack_err_o;

  always #5 clk = ~clk;

  flow_sequencer uut (
    .clk(clk), .rst_n(rst_n), .flow_op_i(flow_op_i), .cond_sel_i(cond_sel_i),
    .target_i(target_i), .carry_i(carry_i), .zero_i(zero_i), .irq_i(irq_i),
    .pc_o(pc_o), .int_en_o(int_en_o), .flag_restore_o(flag_restore_o),
    .carry_restore_o(carry_restore_o), .zero_restore_o(zero_restore_o),
    .stack_err_o(stack_err_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  // Reference model state
  logic [9:0] m_pc;
  logic [9:0] m_stk [31];
  int         m_lvl;
  logic       m_ie, m_sc, m_sz, m_err;

  function automatic logic b_cond(input int cs, input logic c, input logic z);
    if (cs == 0) return 1'b1;
    if (cs == 1 || cs == 2) return c ^ (cs == 2);
    if (cs == 3 || cs == 4) return z ^ (cs == 4);
    return 1'b0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string req_of(input int op, input logic itk);
    if (itk) return "R8";
    case (op)
      0: return "R11";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4, 5: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; flow_op_i = 0; cond_sel_i = 0; target_i = 0;
    carry_i = 0; zero_i = 0; irq_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_pc = 0; m_lvl = 0; m_ie = 0; m_sc = 0; m_sz = 0; m_err = 0;
    // R1 reset state
    check("R1 pc", pc_o, 0);
    check("R1 int_en", int_en_o, 0);
    check("R1 err", stack_err_o, 0);
  endtask

  // Called at a negedge; returns at the next negedge after checking.
  task automatic step(input int op, input int cs, input logic [9:0] tg,
                      input logic c, input logic z, input logic irq);
    logic itk, met, e_rst;
    string rq;
    flow_op_i = 3'(op); cond_sel_i = 3'(cs); target_i = tg;
    carry_i = c; zero_i = z; irq_i = irq;
    #1;
    itk = irq && m_ie;
    met = b_cond(cs, c, z);
    rq  = req_of(op, itk);
    e_rst = !itk && (op == 4 || op == 5) && m_lvl > 0;
    check("R5 restore", flag_restore_o, e_rst);
    if (e_rst) begin
      check("R5 carry", carry_restore_o, m_sc);
      check("R5 zero", zero_restore_o, m_sz);
    end
    if (itk) begin
      if (m_lvl == 31) m_err = 1; else begin m_stk[m_lvl] = m_pc; m_lvl++; end
      m_sc = c; m_sz = z; m_ie = 0; m_pc = 10'h3FF;
    end else begin
      case (op)
        1: m_pc = met ? tg : m_pc + 10'd1;
        2: if (met) begin
             if (m_lvl == 31) m_err = 1; else begin m_stk[m_lvl] = m_pc; m_lvl++; end
             m_pc = tg;
           end else m_pc = m_pc + 10'd1;
        3: if (met && m_lvl > 0) begin m_lvl--; m_pc = m_stk[m_lvl] + 10'd1; end
           else begin if (met) m_err = 1; m_pc = m_pc + 10'd1; end
        4, 5: if (m_lvl > 0) begin m_lvl--; m_pc = m_stk[m_lvl]; m_ie = (op == 4); end
              else begin m_err = 1; m_pc = m_pc + 10'd1; end
        6: begin m_ie = 1; m_pc = m_pc + 10'd1; end
        7: begin m_ie = 0; m_pc = m_pc + 10'd1; end
        default: m_pc = m_pc + 10'd1;
      endcase
    end
    @(negedge clk);
    check({rq, " pc"}, pc_o, m_pc);
    check({rq, " int_en"}, int_en_o, m_ie);
    check(m_err ? "R9/R10 err" : {rq, " err"}, stack_err_o, m_err);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();

    // R11 sequential advance and wrap
    step(1, 0, 10'h3FE, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);   // 3FF -> 000
    // R2 each condition, both outcomes
    for (int cs = 0; cs < 8; cs++) begin
      step(1, cs, 10'h100 + 10'(cs), 1, 0, 0);
      step(1, cs, 10'h200 + 10'(cs), 0, 1, 0);
    end
    // R8 irq ignored while disabled
    step(0, 0, 0, 1, 1, 1);
    // R7 enable, then R8 irq taken, R5/R6 reti restores
    step(6, 0, 0, 0, 0, 0);
    step(2, 0, 10'h050, 0, 0, 0);           // R3 call
    step(0, 0, 0, 1, 0, 1);                 // R8 interrupt
    step(5, 0, 0, 0, 1, 0);                 // R5 R6 reti disable
    step(3, 0, 0, 0, 0, 0);                 // R4 return plus one
    step(6, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 1);
    step(4, 0, 0, 1, 1, 0);                 // R6 reti enable
    step(7, 0, 0, 0, 0, 0);                 // R7 clear

    // R10 underflow
    do_reset();
    step(3, 0, 0, 0, 0, 0);
    step(3, 0, 0, 0, 0, 0);
    do_reset();
    step(4, 0, 0, 0, 0, 0);

    // R9 overflow: 31 calls fill, 32nd dropped
    do_reset();
    for (int i = 0; i < 32; i++) step(2, 0, 10'(i * 3 + 7), 0, 0, 0);
    for (int i = 0; i < 32; i++) step(3, 0, 0, 0, 0, 0);

    // Random mix
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      int op;
      op = int'($urandom_range(0, 7));
      if ((op >= 3 && op <= 5) && m_lvl == 0 && $urandom_range(0, 15) != 0) op = 2;
      if (op == 2 && m_lvl >= 28 && $urandom_range(0, 3) != 0) op = 3;
      if (i % 1000 == 999) do_reset();
      step(op, int'($urandom_range(0, 7)), 10'($urandom), 1'($urandom), 1'($urandom),
           ($urandom_range(0, 7) == 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule